// File: doc/BRIEF.md
# SPI Port Controller

This block is a byte-wide serial peripheral interface port that runs either as bus master or as slave. Software drives it through three byte registers on a small address bus: control at address 0, status at address 1 and data at address 2. Writing the data register while the port is enabled and idle starts an 8-bit full-duplex exchange. The outgoing byte leaves on the data output while the incoming byte is shifted in. When the exchange ends, the received byte can be read back from the data register.

As master, the port generates the serial clock from a selectable divider of the system clock and samples `miso_in`. As slave, it follows an external clock and an active-low select, and drives `miso_out`. Bit order, clock idle level and clock phase can all be selected. A completion flag and a collision flag are readable in status, and an interrupt request follows the completion flag. A select line pulled low while the port is master is treated as a mode fault: the port drops back to slave mode.

Top module: `spi_port`

## Requirements
- R1: After reset the control and status registers read 0x00, `irq` is 0 and `sck_out` rests low.
- R2: In master mode one exchange lasts exactly 16 x (D/2) system clocks, where D is the divisor picked by {status bit 0, control bit 1, control bit 0}: 000=4, 001=16, 010=64, 011=128, 100=2, 101=8, 110=32, 111=64.
- R3: Control bit 5 set shifts the least significant bit first; clear shifts the most significant bit first. This applies to both directions.
- R4: Control bit 3 sets the idle level of the master serial clock, and the clock returns to that level after every exchange.
- R5: With control bit 2 clear, data is sampled on the leading clock edge and changed on the trailing edge. With it set, data is changed on the leading edge and sampled on the trailing edge. The outgoing data stays stable between change edges.
- R6: A data write with control bit 6 set and no exchange running starts an exchange, in master mode if control bit 4 is set. At its end, status bit 7 sets and address 2 reads the byte received.
- R7: `irq` is high exactly when status bit 7, control bit 7 and `glob_ie` are all 1. A pulse on `irq_ack` clears status bit 7.
- R8: Reading status while bit 7 or bit 6 is set, and then reading or writing address 2, clears both flags.
- R9: A data write during an exchange sets status bit 6. The written byte is discarded, and the running exchange completes with the original byte and timing.
- R10: If `ss_n` goes low while the port is an enabled master, control bit 4 clears, status bit 7 sets, the exchange stops, and the clock returns to its idle level.
- R11: In slave mode the port shifts `mosi_in` on edges of `sck_in` while `ss_n` is low and drives `miso_out` by the same phase and order rules. The rate bits have no effect in this mode.
- R12: Status bit 0 is read/write, and status bits 5 to 1 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers flag-clearing side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| glob_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt serviced; clears the completion flag |
| irq | output | 1 | Interrupt request |
| sck_out | output | 1 | Serial clock driven in master mode |
| mosi_out | output | 1 | Serial data out in master mode |
| miso_in | input | 1 | Serial data in for master mode |
| sck_in | input | 1 | External serial clock for slave mode |
| mosi_in | input | 1 | Serial data in for slave mode |
| ss_n | input | 1 | Active-low select; slave enable, mode fault in master mode |
| miso_out | output | 1 | Serial data out in slave mode |

## Verification
The embedded properties watch, on every cycle, that the master clock sits at its idle level whenever no exchange runs, that the outgoing bit only moves on change edges, and that a master exchange that ends normally leaves the completion flag set. They also check that a colliding write neither restarts nor advances the edge count, and that a mode fault clears the master bit and raises the flag. Exchange length for each divisor, bit order on the wire, the received byte, the two flag-clearing paths and slave operation against an externally driven clock can only be shown by the bench's directed scenarios, which compare bytes gathered from the pins with the bytes that were sent.

// File: rtl/spi_port.sv
module spi_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       glob_ie,
  input  logic       irq_ack,
  output logic       irq,
  output logic       sck_out,
  output logic       mosi_out,
  input  logic       miso_in,
  input  logic       sck_in,
  input  logic       mosi_in,
  input  logic       ss_n,
  output logic       miso_out
);
  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [3:0] LAST_EDGE = 4'd15;

  logic [7:0] ctl, rbuf, txs, rxs, rx_nxt;
  logic       dbl, spif, wcol, armed, dout, busy_m, sck_act;
  logic [3:0] ecnt;
  logic [6:0] divc, half;
  logic [2:0] sck_s;
  logic [1:0] ss_s, mosi_s;

  wire lsb    = ctl[5];
  wire cpol   = ctl[3];
  wire cpha   = ctl[2];
  wire en     = ctl[6];
  wire master = en & ctl[4];
  wire slave  = en & ~ctl[4];
  wire ss_act = ~ss_s[1];
  wire fault  = master & ss_act;

  wire s_edge  = slave & ss_act & (sck_s[2] ^ sck_s[1]);
  wire m_edge  = busy_m & (divc == 7'd0);
  wire edge_ev = m_edge | s_edge;
  wire lead    = ~ecnt[0];
  wire samp_ev = edge_ev & (lead ^ cpha);
  wire chg_ev  = edge_ev & ~(lead ^ cpha);
  wire last    = edge_ev & (ecnt == LAST_EDGE);
  wire din     = master ? miso_in : mosi_s[1];
  wire busy    = busy_m | (slave & ss_act & (ecnt != 4'd0));

  wire d_wr    = reg_wr & (reg_addr == A_DATA);
  wire d_acc   = (reg_wr | reg_rd) & (reg_addr == A_DATA);
  wire st_rd   = reg_rd & (reg_addr == A_STAT);
  wire start   = d_wr & en & ~busy;
  wire collide = d_wr & busy;

  always_comb begin
    case ({dbl, ctl[1:0]})
      3'b000:  half = 7'd2;
      3'b001:  half = 7'd8;
      3'b010:  half = 7'd32;
      3'b011:  half = 7'd64;
      3'b100:  half = 7'd1;
      3'b101:  half = 7'd4;
      3'b110:  half = 7'd16;
      default: half = 7'd32;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = ctl;
      A_STAT:  reg_rdata = {spif, wcol, 5'b0, dbl};
      A_DATA:  reg_rdata = rbuf;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign rx_nxt   = lsb ? {din, rxs[7:1]} : {rxs[6:0], din};
  assign sck_out  = cpol ^ sck_act;
  assign mosi_out = dout;
  assign miso_out = dout;
  assign irq      = spif & ctl[7] & glob_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '0;
      ss_s   <= 2'b11;
      mosi_s <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], sck_in};
      ss_s   <= {ss_s[0], ss_n};
      mosi_s <= {mosi_s[0], mosi_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      dbl <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTL) ctl <= reg_wdata;
      if (reg_wr && reg_addr == A_STAT) dbl <= reg_wdata[0];
      if (fault) ctl[4] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spif  <= 1'b0;
      wcol  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (last || fault) spif <= 1'b1;
      else if (irq_ack || (armed && d_acc)) spif <= 1'b0;
      if (collide) wcol <= 1'b1;
      else if (armed && d_acc) wcol <= 1'b0;
      if (st_rd && (spif || wcol)) armed <= 1'b1;
      else if (d_acc) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txs     <= '0;
      rxs     <= '0;
      rbuf    <= '0;
      dout    <= 1'b0;
      busy_m  <= 1'b0;
      sck_act <= 1'b0;
      ecnt    <= '0;
      divc    <= '0;
    end else if (!en || fault) begin
      busy_m  <= 1'b0;
      sck_act <= 1'b0;
      ecnt    <= '0;
    end else if (start) begin
      txs     <= cpha ? reg_wdata : (lsb ? {1'b0, reg_wdata[7:1]} : {reg_wdata[6:0], 1'b0});
      if (!cpha) dout <= lsb ? reg_wdata[0] : reg_wdata[7];
      busy_m  <= master;
      sck_act <= 1'b0;
      ecnt    <= '0;
      divc    <= half - 7'd1;
    end else begin
      if (slave && !ss_act) ecnt <= '0;
      else if (edge_ev) ecnt <= ecnt + 4'd1;
      if (chg_ev) begin
        dout <= lsb ? txs[0] : txs[7];
        txs  <= lsb ? {1'b0, txs[7:1]} : {txs[6:0], 1'b0};
      end
      if (samp_ev) rxs <= rx_nxt;
      if (m_edge) sck_act <= ~sck_act;
      if (busy_m) divc <= (divc == 7'd0) ? half - 7'd1 : divc - 7'd1;
      if (last) begin
        busy_m <= 1'b0;
        rbuf   <= samp_ev ? rx_nxt : rxs;
      end
    end
  end

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_m |-> sck_out == ctl[3]);

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_m && !chg_ev |=> $stable(mosi_out));

  // R6
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_m) && $past(ctl[6]) && ctl[6] && !$past(fault) |-> spif);

  // R9
  wcol_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_wr && busy_m && !m_edge && !fault |=> busy_m && ecnt == $past(ecnt));

  // R10
  mode_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !ctl[4] && spif);
endmodule

// File: tb/spi_port_bench.sv
`timescale 1ns/1ps
module spi_port_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       glob_ie = 1'b1, irq_ack = 1'b0, irq;
  logic       sck_out, mosi_out, miso_in = 1'b0;
  logic       sck_in = 1'b0, mosi_in = 1'b0, ss_n = 1'b1, miso_out;

  int vecs = 0, errs = 0;

  spi_port u_spi_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glob_ie(glob_ie), .irq_ack(irq_ack),
    .irq(irq), .sck_out(sck_out), .mosi_out(mosi_out), .miso_in(miso_in),
    .sck_in(sck_in), .mosi_in(mosi_in), .ss_n(ss_n), .miso_out(miso_out));

  always #10 clk = ~clk;

  function automatic logic bitat(logic [7:0] v, int i, logic ls);
    return ls ? v[i] : v[7-i];
  endfunction

  function automatic int halfof(logic [2:0] r);
    case (r)
      3'd0: return 2;   3'd1: return 8;  3'd2: return 32; 3'd3: return 64;
      3'd4: return 1;   3'd5: return 4;  3'd6: return 16; default: return 32;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic ack;
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  // external slave model answering the master
  logic [7:0] b_tx = '0, b_rx = '0;
  int         b_idx = 0;
  logic       b_cpol = 0, b_cpha = 0, b_lsb = 0, b_on = 0;

  always @(sck_out) if (b_on) begin
    if ((sck_out != b_cpol) ^ b_cpha)
      b_rx = b_lsb ? {mosi_out, b_rx[7:1]} : {b_rx[6:0], mosi_out};
    else begin
      b_idx++;
      if (b_idx >= 0 && b_idx < 8) miso_in = bitat(b_tx, b_idx, b_lsb);
    end
  end

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(0, v); chk("R1 control after reset", v, 8'h00);
    rd(1, v); chk("R1 status after reset", v, 8'h00);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 sck idle after reset", sck_out, 1'b0);
    wr(1, 8'hFF); rd(1, v); chk("R12 status reserved bits", v, 8'h01);
    wr(1, 8'h00); rd(1, v); chk("R12 double bit cleared", v, 8'h00);
  endtask

  task automatic t_master(input logic cp, input logic ph, input logic ls, input logic [2:0] rate,
                          input logic [7:0] tx, input logic [7:0] btx, input bit via_ack);
    int n, h;
    logic [7:0] v;
    h = halfof(rate);
    b_on = 0;
    wr(1, {7'b0, rate[2]});
    wr(0, {1'b1, 1'b1, ls, 1'b1, cp, ph, rate[1:0]});
    chk("R4 idle level before", sck_out, cp);
    b_cpol = cp; b_cpha = ph; b_lsb = ls; b_tx = btx; b_rx = 8'h00;
    b_idx = ph ? -1 : 0;
    miso_in = ph ? 1'b0 : bitat(btx, 0, ls);
    b_on = 1;
    wr(2, tx);
    wait_irq(n);
    chk("R2 exchange length", n, 16 * h);
    chk("R3 R5 bits seen on mosi", b_rx, tx);
    chk("R4 idle level after", sck_out, cp);
    chk("R7 irq raised", irq, 1'b1);
    if (via_ack) begin
      ack;
      chk("R7 irq cleared by ack", irq, 1'b0);
      rd(1, v); chk("R7 flag cleared by ack", v, {7'b0, rate[2]});
      rd(2, v); chk("R6 received byte", v, btx);
    end else begin
      rd(1, v); chk("R6 completion flag", v, {1'b1, 6'b0, rate[2]});
      rd(2, v); chk("R6 received byte", v, btx);
      rd(1, v); chk("R8 flag cleared by sequence", v, {7'b0, rate[2]});
      chk("R8 irq dropped", irq, 1'b0);
    end
    b_on = 0;
  endtask

  task automatic t_collide;
    int n;
    logic [7:0] v;
    b_on = 0;
    wr(1, 8'h00);
    wr(0, 8'hD3);
    b_cpol = 0; b_cpha = 0; b_lsb = 0; b_tx = 8'h5A; b_rx = 8'h00; b_idx = 0;
    miso_in = bitat(8'h5A, 0, 1'b0);
    b_on = 1;
    wr(2, 8'h96);
    repeat (100) @(negedge clk);
    wr(2, 8'h11);
    rd(1, v); chk("R9 collision flag", v, 8'h40);
    wait_irq(n);
    chk("R9 exchange length kept", n, 1024 - 104);
    chk("R9 original byte sent", b_rx, 8'h96);
    rd(1, v); chk("R9 both flags", v, 8'hC0);
    rd(2, v); chk("R9 received byte", v, 8'h5A);
    rd(1, v); chk("R8 both flags cleared", v, 8'h00);
    b_on = 0;
  endtask

  task automatic t_fault;
    logic [7:0] v;
    b_on = 0;
    wr(1, 8'h00);
    wr(0, 8'hD3);
    wr(2, 8'hF0);
    repeat (100) @(negedge clk);
    chk("R10 clock active before fault", sck_out, 1'b1);
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 clock idle after fault", sck_out, 1'b0);
    rd(0, v); chk("R10 master bit cleared", v, 8'hC3);
    rd(1, v); chk("R10 flag set", v, 8'h80);
    chk("R10 irq set", irq, 1'b1);
    ss_n = 1'b1;
    ack;
    rd(1, v); chk("R7 ack clears fault flag", v, 8'h00);
  endtask

  task automatic t_slave(input logic cp, input logic ph, input logic ls,
                         input logic [7:0] tx, input logic [7:0] mtx);
    int hh = 10;
    logic [7:0] srx = 8'h00, v;
    sck_in = cp; ss_n = 1'b1; mosi_in = 1'b0;
    wr(1, 8'h00);
    wr(0, {1'b0, 1'b1, ls, 1'b0, cp, ph, 2'b11});
    wr(2, tx);
    ss_n = 1'b0;
    repeat (hh) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (!ph) begin
        mosi_in = bitat(mtx, i, ls);
        repeat (hh) @(negedge clk);
        srx = ls ? {miso_out, srx[7:1]} : {srx[6:0], miso_out};
        sck_in = ~cp;
        repeat (hh) @(negedge clk);
        sck_in = cp;
      end else begin
        sck_in = ~cp;
        mosi_in = bitat(mtx, i, ls);
        repeat (hh) @(negedge clk);
        srx = ls ? {miso_out, srx[7:1]} : {srx[6:0], miso_out};
        sck_in = cp;
        repeat (hh) @(negedge clk);
      end
    end
    repeat (hh) @(negedge clk);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 bits seen on miso", srx, tx);
    rd(1, v); chk("R11 completion flag", v, 8'h80);
    rd(2, v); chk("R11 received byte", v, mtx);
    rd(1, v); chk("R8 flag cleared after slave", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_master(1'b0, 1'b0, 1'b0, 3'b000, 8'hA7, 8'h3C, 1'b1);
    t_master(1'b1, 1'b1, 1'b1, 3'b100, 8'h5B, 8'hC1, 1'b0);
    t_master(1'b0, 1'b1, 1'b0, 3'b101, 8'h81, 8'h7E, 1'b1);
    t_master(1'b1, 1'b0, 1'b1, 3'b011, 8'h2D, 8'hE4, 1'b0);
    t_collide;
    t_fault;
    t_slave(1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C);
    t_slave(1'b1, 1'b1, 1'b1, 8'h4E, 8'hB2);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule